// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks an integer-multiplier PLL through a safe change of multiplier. A single-cycle `start` pulse hands it a new multiplier/bandwidth word. The block then issues four register writes on consecutive cycles:

1. It powers the PLL down and cuts its output and direct paths.
2. It loads the multiplier word.
3. It loads a fixed divider word that sets both the pre-divider and the post-divider to one.
4. It releases power-down.

After that it samples the lock flag at a programmable spacing. When lock appears, it turns on the PLL's clock output and reports success. When lock has not appeared after a bounded number of samples, it reports failure and leaves the output disabled.

Each write goes out as a one-cycle strobe with an address and a data word, in strict order. The block keeps its own copy of the control register. Each control write is therefore a read-modify-write of that copy: bits outside the five control flags keep their value.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `busy`, `done`, `err` and `wr_en` are low, and no write is issued while `start` stays low.
- R2: A `start` pulse with `busy` low is accepted. In the next cycle a write goes to address 0 (control). Its data is the held control value with bit 0 (power-down) set and bits 1 to 4 (bypass, direct-in, direct-out, clock enable) cleared, and all other bits unchanged. The held control value after reset is `CTRL_RST`.
- R3: One cycle after the first control write, address 1 (multiplier) receives the `mult_word` captured at the accepted `start`.
- R4: One cycle after the multiplier write, address 2 (divider) receives 0x00302062.
- R5: One cycle after the divider write, address 0 receives the first control word with bit 0 cleared.
- R6: With W the `poll_interval` captured at `start`, lock samples are taken (W+2), 2(W+2), 3(W+2), … cycles after the release write. Only bit 0 of `stat_word` is used, and only in those cycles. No write occurs between the release write and the outcome.
- R7: If a sample sees lock, the next cycle writes address 0 with the release word plus bit 4 set, and `done` is high for exactly the cycle after that.
- R8: If none of `MAX_POLLS` samples sees lock, `err` is high for exactly the cycle after the last sample, and no control write with bit 4 set occurs.
- R9: `busy` is high from the cycle after the accepted `start` through the cycle before `done` or `err`, and is low afterwards. A `start` while `busy` is high changes nothing: not the writes, not the captured values, not the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to reprogram |
| mult_word | input | DATA_W | Multiplier/bandwidth word, captured on accepted start |
| poll_interval | input | IVL_W | Extra wait cycles between lock samples, captured on accepted start |
| stat_word | input | STAT_W | PLL status; bit 0 is the lock flag |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 2 | Write target: 0 control, 1 multiplier, 2 divider |
| wr_data | output | DATA_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success indication |
| err | output | 1 | One-cycle lock-timeout indication |

## Verification
The bench builds the block with `MAX_POLLS` = 4, a 3-bit interval and a reset control value of 0x01000003. This reset value has bypass set and an unrelated high bit set, so both the clearing of the flags and the preservation of the other bits are visible. With so few samples allowed, the bench can sweep every lock delay from zero to two cycles past the last sample, for every interval from 0 to 3. This covers lock exactly on each sample boundary, lock one cycle too late for a sample, lock on the final sample and a timeout. A stale lock flag before release and a `start` pulse in mid-wait are mixed into the sweep, and the held control value carries over from run to run.

// File: rtl/pll_seq_pkg.sv
// Package: shared state encoding, register addresses, control bit positions
// and the fixed divider word for the PLL reprogramming sequencer.
package pll_seq_pkg;

    // Sequencer states, in the order the sequence visits them.
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_PWRDN = 4'd1,
        ST_MULT  = 4'd2,
        ST_DIVS  = 4'd3,
        ST_PWRUP = 4'd4,
        ST_WAIT  = 4'd5,
        ST_POLL  = 4'd6,
        ST_CLKEN = 4'd7,
        ST_OK    = 4'd8,
        ST_FAIL  = 4'd9
    } seq_state_e;

    // Register addresses presented on the write port.
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_MULT = 2'd1;
    localparam logic [1:0] RA_DIVS = 2'd2;

    // Control register bit positions.
    localparam int CB_PDN   = 0;
    localparam int CB_BYP   = 1;
    localparam int CB_DIN   = 2;
    localparam int CB_DOUT  = 3;
    localparam int CB_CLKEN = 4;

    // Divider word setting pre- and post-divider to one.
    localparam logic [31:0] DIVS_UNITY = 32'h0030_2062;

endpackage

// File: rtl/pll_seq_timer.sv
// Module: pll_seq_timer
// Counts the wait interval between lock samples and the samples already spent.
// Assumes: the FSM raises ivl_load on each entry to the wait state and
// ivl_run while waiting; accept clears the sample count.
module pll_seq_timer #(
    parameter int IVL_W     = 16,
    parameter int MAX_POLLS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [IVL_W-1:0] ivl_in,
    input  logic             ivl_load,
    input  logic             ivl_run,
    input  logic             poll_miss,
    output logic             ivl_zero,
    output logic             last_poll
);
    localparam int PC_W = $clog2(MAX_POLLS + 1);
    localparam logic [PC_W-1:0] LAST_IDX = PC_W'(MAX_POLLS - 1);

    logic [IVL_W-1:0] ivl_hold;
    logic [IVL_W-1:0] ivl_cnt;
    logic [PC_W-1:0]  poll_cnt;

    // Capture the interval at an accepted start so later input changes do not matter.
    always_ff @(posedge clk) begin
        if (!rst_n)      ivl_hold <= '0;
        else if (accept) ivl_hold <= ivl_in;
    end

    // Down-count the wait interval; reloaded on each wait entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ivl_cnt <= '0;
        else if (ivl_load)                 ivl_cnt <= ivl_hold;
        else if (ivl_run && ivl_cnt != '0) ivl_cnt <= ivl_cnt - 1'b1;
    end

    // Count lock samples that missed, cleared per sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)         poll_cnt <= '0;
        else if (accept)    poll_cnt <= '0;
        else if (poll_miss) poll_cnt <= poll_cnt + 1'b1;
    end

    // Decode the interval end and the final allowed sample.
    always_comb begin
        ivl_zero  = (ivl_cnt == '0);
        last_poll = (poll_cnt == LAST_IDX);
    end
endmodule

// File: rtl/pll_seq_fsm.sv
// Module: pll_seq_fsm
// Sequence state machine: power-down, two configuration writes, release,
// bounded lock polling, clock enable, then a one-cycle outcome state.
// Assumes: timer outputs are registered; lock is sampled only in ST_POLL.
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       lock,
    input  logic       ivl_zero,
    input  logic       last_poll,
    output seq_state_e state,
    output logic       accept,
    output logic       ivl_load,
    output logic       ivl_run,
    output logic       poll_miss,
    output logic       busy,
    output logic       done,
    output logic       err
);
    seq_state_e nxt;
    logic       idle_like;

    // Hold the current sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Accept start only when no sequence is running.
    always_comb begin
        idle_like = (state == ST_IDLE) || (state == ST_OK) || (state == ST_FAIL);
        accept    = start && idle_like;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_OK, ST_FAIL: nxt = accept ? ST_PWRDN : ST_IDLE;
            ST_PWRDN: nxt = ST_MULT;
            ST_MULT:  nxt = ST_DIVS;
            ST_DIVS:  nxt = ST_PWRUP;
            ST_PWRUP: nxt = ST_WAIT;
            ST_WAIT:  nxt = ivl_zero ? ST_POLL : ST_WAIT;
            ST_POLL: begin
                if (lock)           nxt = ST_CLKEN;
                else if (last_poll) nxt = ST_FAIL;
                else                nxt = ST_WAIT;
            end
            ST_CLKEN: nxt = ST_OK;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Timer controls and status decode.
    always_comb begin
        poll_miss = (state == ST_POLL) && !lock;
        ivl_load  = (state == ST_PWRUP) || (poll_miss && !last_poll);
        ivl_run   = (state == ST_WAIT);
        busy      = (state != ST_IDLE) && !idle_like;
        done      = (state == ST_OK);
        err       = (state == ST_FAIL);
    end
endmodule

// File: rtl/pll_seq_wport.sv
// Module: pll_seq_wport
// Register write port: turns the sequence state into one-cycle write strobes
// and keeps the held control value that every control write modifies.
// Assumes: at most one write per cycle, chosen by the state alone.
module pll_seq_wport
    import pll_seq_pkg::*;
#(
    parameter int                 DATA_W   = 32,
    parameter logic [DATA_W-1:0]  CTRL_RST = DATA_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic [DATA_W-1:0] mult_in,
    output logic              wr_en,
    output logic [1:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [DATA_W-1:0] M_PDN   = DATA_W'(1) << CB_PDN;
    localparam logic [DATA_W-1:0] M_CLKEN = DATA_W'(1) << CB_CLKEN;
    localparam logic [DATA_W-1:0] M_PATHS = (DATA_W'(1) << CB_BYP) | (DATA_W'(1) << CB_DIN)
                                          | (DATA_W'(1) << CB_DOUT) | M_CLKEN;
    localparam logic [DATA_W-1:0] DIVS_W  = DATA_W'(DIVS_UNITY);

    logic [DATA_W-1:0] ctrl_held;
    logic [DATA_W-1:0] mult_hold;

    // Capture the multiplier word at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      mult_hold <= '0;
        else if (accept) mult_hold <= mult_in;
    end

    // Follow every control write so the next one modifies the current value.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_held <= CTRL_RST;
        else if (wr_en && wr_addr == RA_CTRL) ctrl_held <= wr_data;
    end

    // Decode the write for the current state.
    always_comb begin
        wr_en   = 1'b1;
        wr_addr = RA_CTRL;
        wr_data = '0;
        unique case (state)
            ST_PWRDN: wr_data = (ctrl_held | M_PDN) & ~M_PATHS;
            ST_MULT: begin
                wr_addr = RA_MULT;
                wr_data = mult_hold;
            end
            ST_DIVS: begin
                wr_addr = RA_DIVS;
                wr_data = DIVS_W;
            end
            ST_PWRUP: wr_data = ctrl_held & ~M_PDN;
            ST_CLKEN: wr_data = ctrl_held | M_CLKEN;
            default:  wr_en   = 1'b0;
        endcase
    end
endmodule

// File: rtl/pll_reprog_seq.sv
// Module: pll_reprog_seq
// Top of the PLL reprogramming sequencer: joins the state machine, the
// poll timer and the register write port.
// Assumes: stat_word bit 0 is the PLL lock flag, synchronous to clk.
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                STAT_W    = 8,
    parameter int                IVL_W     = 16,
    parameter int                MAX_POLLS = 100,
    parameter logic [DATA_W-1:0] CTRL_RST  = DATA_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] mult_word,
    input  logic [IVL_W-1:0]  poll_interval,
    input  logic [STAT_W-1:0] stat_word,
    output logic              wr_en,
    output logic [1:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              err
);
    seq_state_e state;
    logic       accept;
    logic       ivl_load;
    logic       ivl_run;
    logic       poll_miss;
    logic       ivl_zero;
    logic       last_poll;

    pll_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lock      (stat_word[0]),
        .ivl_zero  (ivl_zero),
        .last_poll (last_poll),
        .state     (state),
        .accept    (accept),
        .ivl_load  (ivl_load),
        .ivl_run   (ivl_run),
        .poll_miss (poll_miss),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    pll_seq_timer #(
        .IVL_W     (IVL_W),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .ivl_in    (poll_interval),
        .ivl_load  (ivl_load),
        .ivl_run   (ivl_run),
        .poll_miss (poll_miss),
        .ivl_zero  (ivl_zero),
        .last_poll (last_poll)
    );

    pll_seq_wport #(
        .DATA_W   (DATA_W),
        .CTRL_RST (CTRL_RST)
    ) u_wport (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .accept  (accept),
        .mult_in (mult_word),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );
endmodule

// File: rtl/pll_reprog_seq_chk.sv
// Module: pll_reprog_seq_chk
// Port-level properties of the sequencer, bound to every instance of the top.
module pll_reprog_seq_chk
    import pll_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] stat_word,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              done,
    input logic              err
);
    // R4
    mult_then_divs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_MULT) |=> (wr_en && wr_addr == RA_DIVS && wr_data == DATA_W'(DIVS_UNITY)));

    // R3
    pdn_then_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CTRL && wr_data[CB_PDN]) |=> (wr_en && wr_addr == RA_MULT));

    // R2
    ctrl_paths_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CTRL) |-> (wr_data[CB_DOUT:CB_BYP] == 3'b000));

    // R7
    clken_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CTRL && wr_data[CB_CLKEN]) |-> $past(stat_word[0]));

    // R7
    done_after_clken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en && wr_data[CB_CLKEN]));

    // R8
    outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err));

    // R9
    write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
    .DATA_W (DATA_W),
    .STAT_W (STAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_word (stat_word),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/pll_reprog_seq_test.sv
// Bench: sweeps lock delay against every poll interval for a small poll bound,
// predicting every output of every cycle arithmetically.
module pll_reprog_seq_test;
    localparam int          DW   = 32;
    localparam int          SW   = 4;
    localparam int          IW   = 3;
    localparam int          MP   = 4;
    localparam logic [31:0] CRST = 32'h0100_0003;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] mult_word = '0;
    logic [IW-1:0] poll_interval = '0;
    logic [SW-1:0] stat_word = '0;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic          busy;
    logic          done;
    logic          err;

    int vectors = 0;
    int fails = 0;
    logic [31:0] ctrl_m = CRST;

    always #10 clk = ~clk;

    pll_reprog_seq #(
        .DATA_W    (DW),
        .STAT_W    (SW),
        .IVL_W     (IW),
        .MAX_POLLS (MP),
        .CTRL_RST  (CRST)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .mult_word     (mult_word),
        .poll_interval (poll_interval),
        .stat_word     (stat_word),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .busy          (busy),
        .done          (done),
        .err           (err)
    );

    // Compare one packed output vector: {busy,done,err,wr_en,addr,data}.
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_out();
        logic [31:0] d;
        d = wr_en ? wr_data : 32'h0;
        return {26'h0, busy, done, err, wr_en, wr_addr, d};
    endfunction

    function automatic logic [63:0] pack_exp(bit b, bit d, bit e, bit w, logic [1:0] a, logic [31:0] v);
        return {26'h0, b, d, e, w, (w ? a : 2'b00), (w ? v : 32'h0)};
    endfunction

    // One full sequence: lock appears dly cycles after the release write.
    task automatic run_case(input int ivl, input int dly, input logic [31:0] mult, input bit stale);
        int per;
        int need;
        bit ok;
        int pfin;
        int endr;
        logic [31:0] pdw;
        logic [31:0] puw;
        logic [31:0] enw;
        per  = ivl + 2;
        need = (dly == 0) ? 1 : (dly + per - 1) / per;
        ok   = (need <= MP);
        pfin = ok ? 4 + need * per : 4 + MP * per;
        endr = ok ? pfin + 2 : pfin + 1;
        pdw  = (ctrl_m | 32'h1) & ~32'h1E;
        puw  = pdw & ~32'h1;
        enw  = puw | 32'h10;
        @(negedge clk);
        start = 1'b1;
        mult_word = mult;
        poll_interval = IW'(ivl);
        stat_word = stale ? 4'b1011 : 4'b1010;
        for (int r = 1; r <= endr + 1; r++) begin
            logic [63:0] e;
            string tag;
            @(negedge clk);
            e = pack_exp(r <= endr - 1, ok && r == endr, !ok && r == endr, 1'b0, 2'b00, 32'h0);
            tag = "R6";
            if (r == 1)      begin e = pack_exp(1, 0, 0, 1, 2'd0, pdw);          tag = "R2"; end
            else if (r == 2) begin e = pack_exp(1, 0, 0, 1, 2'd1, mult);         tag = "R3"; end
            else if (r == 3) begin e = pack_exp(1, 0, 0, 1, 2'd2, 32'h0030_2062); tag = "R4"; end
            else if (r == 4) begin e = pack_exp(1, 0, 0, 1, 2'd0, puw);          tag = "R5"; end
            else if (ok && r == pfin + 1) begin e = pack_exp(1, 0, 0, 1, 2'd0, enw); tag = "R7"; end
            else if (r == endr) tag = ok ? "R7" : "R8";
            else if (r > endr)  tag = "R9";
            chk(tag, pack_out(), e);
            // R9: a start during the wait must be ignored
            start = (r == 6);
            mult_word = ~mult;
            poll_interval = IW'(ivl + 1);
            stat_word = {3'b101, (r >= 4 && r - 4 >= dly) || (stale && r < 4)};
        end
        stat_word = '0;
        ctrl_m = ok ? enw : puw;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle with no start
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", pack_out(), pack_exp(0, 0, 0, 0, 2'b00, 32'h0));
        end
        for (int ivl = 0; ivl < 4; ivl++) begin
            for (int dly = 0; dly <= MP * (ivl + 2) + 2; dly++) begin
                run_case(ivl, dly, 32'hA500_0000 ^ (ivl << 8) ^ dly, dly[0]);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule